// File: doc/BRIEF.md
# Block-Protected Scratchpad Page Memory

This block sits in front of a byte array of 80 pages, 32 bytes per page, and lets a host commit data to it only through a staging buffer. The host opens a transfer by naming a target byte address, streams bytes into a one-page scratchpad, and can read any scratchpad byte back to confirm what landed there. A copy strobe then hands the staged bytes to the array, but only if it carries an authorization word matching the latched target and the last offset written. The commit takes effect after a self-timed programming interval. The interval is a clock count, so a bench can shorten it.

The pages form protection groups of eight consecutive pages, which gives ten groups at the default size. Each group has its own two-bit mode input. A group can take plain overwrites, or it can refuse every copy. In its third mode it emulates one-time-programmable memory: bits may only fall from 1 to 0, so each committed byte becomes the bitwise AND of the old and the new value. While programming is under way the busy flag is high, the array keeps returning its previous contents, and the scratchpad accepts no further requests.

Top module: `bps_mem`

## Requirements
- R1: After reset busy_o is low, tgt_addr_o and end_off_o are zero, every scratchpad byte reads 8'h00 and every array byte reads 8'hFF.
- R2: A start pulse latches sp_addr_i as the target address, with the page in bits [11:5] and the starting offset in bits [4:0]. It loads the write pointer and end_off_o with the starting offset and forgets all previously written bytes. A write in the same cycle as a start is dropped.
- R3: Each write stores sp_wdata_i at the write pointer and reports that offset on end_off_o. It then advances the pointer, wrapping from offset 31 to offset 0 within the same page.
- R4: sp_rdata_o returns the scratchpad byte at sp_roff_i one cycle after the offset is applied.
- R5: A copy strobe is accepted only if copy_auth_i equals {tgt_addr_o, end_off_o} (target in bits [16:5]), at least one byte has been written since the last start, and the target page is below 80. Otherwise busy_o stays low and the array is unchanged.
- R6: The mode of page p is grp_mode_i[2g+1:2g] with g = p/8. Code 00 overwrites, code 10 stores old AND new, and codes 01 and 11 refuse the copy: busy_o stays low and the array is unchanged.
- R7: An accepted copy raises busy_o in the cycle after the strobe and holds it for exactly PROG_CYCLES cycles. The array changes at the edge where busy_o falls, and only the bytes written since the last start are modified.
- R8: While busy_o is high, array reads return the previous contents, including at the commit edge. Starts, writes and copy strobes are ignored, so tgt_addr_o, end_off_o and the scratchpad stay unchanged.
- R9: arr_rdata_o returns the array byte at arr_raddr_i one cycle later. Addresses at or beyond 2560 read as 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sp_start_i | input | 1 | Open a transfer at sp_addr_i |
| sp_addr_i | input | 12 | Target byte address (page, offset) |
| sp_we_i | input | 1 | Write one byte into the scratchpad |
| sp_wdata_i | input | 8 | Scratchpad write data |
| sp_roff_i | input | 5 | Scratchpad readback offset |
| sp_rdata_o | output | 8 | Scratchpad readback data |
| tgt_addr_o | output | 12 | Latched target address |
| end_off_o | output | 5 | Offset of the last byte written |
| copy_i | input | 1 | Copy strobe |
| copy_auth_i | input | 17 | Authorization word for the copy |
| grp_mode_i | input | 20 | Two-bit mode per protection group |
| arr_raddr_i | input | 12 | Array read address |
| arr_rdata_o | output | 8 | Array read data |
| busy_o | output | 1 | Programming in progress |

## Verification
Two pairs of events can meet in one cycle, and the bench provokes both on purpose. An array read of the target page is issued in the first busy cycle and again in the cycle whose edge commits the page. Both reads must return the old byte, and a readback after busy_o falls must return the merged byte. A start and a write are also driven together, both at idle and during programming together with a fresh copy strobe. These checks are judged by end_off_o, the scratchpad readback and the busy length staying exactly as the reference model predicts.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    GM_OPEN = 2'b00,
    GM_LOCK = 2'b01,
    GM_OTP  = 2'b10,
    GM_RSVD = 2'b11
  } grp_mode_e;

  function automatic logic mode_writable(input logic [1:0] m);
    return (grp_mode_e'(m) == GM_OPEN) || (grp_mode_e'(m) == GM_OTP);
  endfunction
endpackage

// File: rtl/bps_scratch.sv
module bps_scratch #(
  parameter int PAGE_BYTES = 32,
  parameter int AW         = 12,
  localparam int OW        = $clog2(PAGE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    busy_i,
  input  logic                    start_i,
  input  logic [AW-1:0]           addr_i,
  input  logic                    we_i,
  input  logic [7:0]              wdata_i,
  input  logic [OW-1:0]           roff_i,
  output logic [7:0]              rdata_o,
  output logic [AW-1:0]           tgt_o,
  output logic [OW-1:0]           end_o,
  output logic [PAGE_BYTES-1:0]   mask_o,
  output logic [PAGE_BYTES*8-1:0] data_o
);
  logic [7:0]            sp_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [AW-1:0]         tgt_q;
  logic [OW-1:0]         ptr_q, end_q, ptr_nxt;
  logic [7:0]            rdata_q;

  assign ptr_nxt = (ptr_q == OW'(PAGE_BYTES - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) sp_q[i] <= '0;
      mask_q  <= '0;
      tgt_q   <= '0;
      ptr_q   <= '0;
      end_q   <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= sp_q[roff_i];
      if (!busy_i) begin
        if (start_i) begin
          tgt_q  <= addr_i;
          ptr_q  <= addr_i[OW-1:0];
          end_q  <= addr_i[OW-1:0];
          mask_q <= '0;
        end else if (we_i) begin
          sp_q[ptr_q]   <= wdata_i;
          mask_q[ptr_q] <= 1'b1;
          end_q         <= ptr_q;
          ptr_q         <= ptr_nxt;
        end
      end
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign data_o[g*8 +: 8] = sp_q[g];
  end

  assign rdata_o = rdata_q;
  assign tgt_o   = tgt_q;
  assign end_o   = end_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
#(
  parameter int PAGES       = 80,
  parameter int GRP_PAGES   = 8,
  parameter int NGRP        = 10,
  parameter int AW          = 12,
  parameter int OW          = 5,
  parameter int PROG_CYCLES = 500000,
  localparam int PW         = AW - OW,
  localparam int CW         = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             copy_i,
  input  logic [AW+OW-1:0] auth_i,
  input  logic [AW-1:0]    tgt_i,
  input  logic [OW-1:0]    end_i,
  input  logic             any_i,
  input  logic [2*NGRP-1:0] grp_mode_i,
  output logic             busy_o,
  output logic             commit_o,
  output logic [PW-1:0]    page_o,
  output logic             otp_o
);
  logic [PW-1:0] page;
  logic          in_range, accept;
  logic [1:0]    mode;
  int            grp_idx;

  logic          busy_q, otp_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] page_q;

  always_comb begin
    page     = tgt_i[AW-1:OW];
    in_range = {1'b0, page} < (PW+1)'(PAGES);
    grp_idx  = in_range ? int'(page) / GRP_PAGES : 0;
    mode     = in_range ? grp_mode_i[2*grp_idx +: 2] : GM_LOCK;
    accept   = copy_i && !busy_q && (auth_i == {tgt_i, end_i}) && any_i
               && in_range && mode_writable(mode);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
      otp_q  <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(PROG_CYCLES - 1);
      page_q <= page;
      otp_q  <= (grp_mode_e'(mode) == GM_OTP);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == '0);
  assign page_o   = page_q;
  assign otp_o    = otp_q;
endmodule

// File: rtl/bps_array.sv
module bps_array #(
  parameter int PAGES      = 80,
  parameter int PAGE_BYTES = 32,
  parameter int AW         = 12,
  parameter int PW         = 7,
  localparam int DEPTH     = PAGES * PAGE_BYTES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [PW-1:0]           page_i,
  input  logic                    otp_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [7:0]              rdata_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [7:0]    rdata_q;
  logic [AW-1:0] base;

  assign base = AW'(int'(page_i) * PAGE_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      rdata_q <= '0;
    end else begin
      rdata_q <= ({1'b0, raddr_i} < (AW+1)'(DEPTH)) ? mem_q[raddr_i] : 8'h00;
      if (commit_i) begin
        for (int b = 0; b < PAGE_BYTES; b++) begin
          if (mask_i[b])
            mem_q[base + AW'(b)] <= otp_i ? (mem_q[base + AW'(b)] & data_i[b*8 +: 8])
                                          : data_i[b*8 +: 8];
        end
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bps_mem.sv
module bps_mem #(
  parameter int PAGES       = 80,
  parameter int PAGE_BYTES  = 32,
  parameter int GRP_PAGES   = 8,
  parameter int PROG_CYCLES = 500000,
  localparam int NGRP       = (PAGES + GRP_PAGES - 1) / GRP_PAGES,
  localparam int DEPTH      = PAGES * PAGE_BYTES,
  localparam int AW         = $clog2(DEPTH),
  localparam int OW         = $clog2(PAGE_BYTES),
  localparam int PW         = AW - OW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sp_start_i,
  input  logic [AW-1:0]        sp_addr_i,
  input  logic                 sp_we_i,
  input  logic [7:0]           sp_wdata_i,
  input  logic [OW-1:0]        sp_roff_i,
  output logic [7:0]           sp_rdata_o,
  output logic [AW-1:0]        tgt_addr_o,
  output logic [OW-1:0]        end_off_o,
  input  logic                 copy_i,
  input  logic [AW+OW-1:0]     copy_auth_i,
  input  logic [2*NGRP-1:0]    grp_mode_i,
  input  logic [AW-1:0]        arr_raddr_i,
  output logic [7:0]           arr_rdata_o,
  output logic                 busy_o
);
  logic                    busy, commit, otp;
  logic [PW-1:0]           page;
  logic [PAGE_BYTES-1:0]   mask;
  logic [PAGE_BYTES*8-1:0] sp_data;

  bps_scratch #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) u_scratch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy),
    .start_i (sp_start_i),
    .addr_i  (sp_addr_i),
    .we_i    (sp_we_i),
    .wdata_i (sp_wdata_i),
    .roff_i  (sp_roff_i),
    .rdata_o (sp_rdata_o),
    .tgt_o   (tgt_addr_o),
    .end_o   (end_off_o),
    .mask_o  (mask),
    .data_o  (sp_data)
  );

  bps_ctrl #(
    .PAGES(PAGES), .GRP_PAGES(GRP_PAGES), .NGRP(NGRP),
    .AW(AW), .OW(OW), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .copy_i     (copy_i),
    .auth_i     (copy_auth_i),
    .tgt_i      (tgt_addr_o),
    .end_i      (end_off_o),
    .any_i      (|mask),
    .grp_mode_i (grp_mode_i),
    .busy_o     (busy),
    .commit_o   (commit),
    .page_o     (page),
    .otp_o      (otp)
  );

  bps_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .AW(AW), .PW(PW)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .page_i   (page),
    .otp_i    (otp),
    .mask_i   (mask),
    .data_i   (sp_data),
    .raddr_i  (arr_raddr_i),
    .rdata_o  (arr_rdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/bps_mem_chk.sv
module bps_mem_chk #(
  parameter int PAGES       = 80,
  parameter int GRP_PAGES   = 8,
  parameter int NGRP        = 10,
  parameter int AW          = 12,
  parameter int OW          = 5,
  parameter int PROG_CYCLES = 500000,
  localparam int PW         = AW - OW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              copy_i,
  input logic [AW+OW-1:0]  copy_auth_i,
  input logic [AW-1:0]     tgt_addr_o,
  input logic [OW-1:0]     end_off_o,
  input logic [2*NGRP-1:0] grp_mode_i
);
  int unsigned   busy_run;
  logic [PW-1:0] pg;
  logic          pg_ok, locked;
  int            gi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= 0;
    else         busy_run <= busy_o ? busy_run + 1 : 0;
  end

  always_comb begin
    pg     = tgt_addr_o[AW-1:OW];
    pg_ok  = {1'b0, pg} < (PW+1)'(PAGES);
    gi     = pg_ok ? int'(pg) / GRP_PAGES : 0;
    locked = pg_ok && grp_mode_i[2*gi];
  end

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_run == PROG_CYCLES);

  p_busy_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run < PROG_CYCLES);

  p_auth_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_i && !busy_o && copy_auth_i != {tgt_addr_o, end_off_o}) |=> !busy_o);

  p_lock_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_i && !busy_o && locked) |=> !busy_o);

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(tgt_addr_o) && $stable(end_off_o)));
endmodule

bind bps_mem bps_mem_chk #(
  .PAGES(PAGES), .GRP_PAGES(GRP_PAGES), .NGRP(NGRP),
  .AW(AW), .OW(OW), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .copy_i      (copy_i),
  .copy_auth_i (copy_auth_i),
  .tgt_addr_o  (tgt_addr_o),
  .end_off_o   (end_off_o),
  .grp_mode_i  (grp_mode_i)
);

// File: tb/bps_mem_tb.sv
module bps_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 12;
  localparam int NPAGE      = 80;
  localparam int PB         = 32;
  localparam int DEPTH      = NPAGE * PB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sp_start_i = 1'b0;
  logic [11:0] sp_addr_i = '0;
  logic        sp_we_i = 1'b0;
  logic [7:0]  sp_wdata_i = '0;
  logic [4:0]  sp_roff_i = '0;
  logic [7:0]  sp_rdata_o;
  logic [11:0] tgt_addr_o;
  logic [4:0]  end_off_o;
  logic        copy_i = 1'b0;
  logic [16:0] copy_auth_i = '0;
  logic [19:0] grp_mode_i = '0;
  logic [11:0] arr_raddr_i = '0;
  logic [7:0]  arr_rdata_o;
  logic        busy_o;

  bps_mem #(.PROG_CYCLES(PROG)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  m_mem [DEPTH];
  logic [7:0]  m_sp  [PB];
  logic [11:0] m_tgt;
  logic [4:0]  m_ptr, m_end;
  logic [31:0] m_mask;

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [1:0] mode_of(input int pg, input logic [19:0] modes);
    return modes[2*(pg/8) +: 2];
  endfunction

  function automatic bit exp_accept(input logic [16:0] auth, input logic [19:0] modes);
    int pg = int'(m_tgt[11:5]);
    if (auth != {m_tgt, m_end} || m_mask == 0 || pg >= NPAGE) return 0;
    return (mode_of(pg, modes) == 2'b00) || (mode_of(pg, modes) == 2'b10);
  endfunction

  task automatic sp_begin(input logic [11:0] a);
    sp_addr_i = a; sp_start_i = 1; cyc(); sp_start_i = 0;
    m_tgt = a; m_ptr = a[4:0]; m_end = a[4:0]; m_mask = 0;
  endtask

  task automatic sp_put(input logic [7:0] d);
    sp_wdata_i = d; sp_we_i = 1; cyc(); sp_we_i = 0;
    m_sp[m_ptr] = d; m_mask[m_ptr] = 1; m_end = m_ptr; m_ptr = m_ptr + 1;
  endtask

  task automatic verify_sp(input string req);
    for (int o = 0; o < PB; o++) begin
      sp_roff_i = 5'(o); cyc();
      check(req, {24'd0, sp_rdata_o}, {24'd0, m_sp[o]});
    end
  endtask

  task automatic verify_page(input int pg, input string req);
    for (int b = 0; b < PB; b++) begin
      arr_raddr_i = 12'(pg*PB + b); cyc();
      check(req, {24'd0, arr_rdata_o}, {24'd0, m_mem[pg*PB + b]});
    end
  endtask

  task automatic do_copy(input logic [16:0] auth, input bit intrude);
    bit acc = exp_accept(auth, grp_mode_i);
    int pg  = int'(m_tgt[11:5]);
    bit otp = acc && (mode_of(pg, grp_mode_i) == 2'b10);
    int probe = pg*PB + int'(m_end);
    copy_auth_i = auth; copy_i = 1; cyc(); copy_i = 0;
    check(acc ? "R7 busy rise" : "R5/R6 abort busy", {31'd0, busy_o}, {31'd0, acc});
    if (acc) begin
      arr_raddr_i = 12'(probe);
      if (intrude) begin
        sp_addr_i = 12'($urandom_range(0, 4095)); sp_start_i = 1;
        sp_wdata_i = 8'($urandom); sp_we_i = 1;
      end
      cyc(); sp_start_i = 0; sp_we_i = 0;
      check("R8 old data while busy", {24'd0, arr_rdata_o}, {24'd0, m_mem[probe]});
      if (intrude) begin copy_auth_i = {m_tgt, m_end}; copy_i = 1; end
      cyc(); copy_i = 0;
      for (int k = 3; k < PROG; k++) cyc();
      check("R7 busy held", {31'd0, busy_o}, 32'd1);
      cyc();
      check("R8 read at commit edge", {24'd0, arr_rdata_o}, {24'd0, m_mem[probe]});
      check("R7 busy fall", {31'd0, busy_o}, 32'd0);
      for (int b = 0; b < PB; b++)
        if (m_mask[b]) m_mem[pg*PB + b] = otp ? (m_mem[pg*PB + b] & m_sp[b]) : m_sp[b];
      if (intrude) begin
        check("R8 tgt frozen", {20'd0, tgt_addr_o}, {20'd0, m_tgt});
        check("R8 end frozen", {27'd0, end_off_o}, {27'd0, m_end});
        verify_sp("R8 scratch frozen");
      end
    end else begin
      cyc();
      check("R5/R6 stays idle", {31'd0, busy_o}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    for (int i = 0; i < PB; i++) m_sp[i] = 8'h00;
    m_tgt = 0; m_ptr = 0; m_end = 0; m_mask = 0;
    repeat (3) cyc();
    rst_ni = 1; cyc();

    // R1 reset state
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 tgt", {20'd0, tgt_addr_o}, 32'd0);
    check("R1 end", {27'd0, end_off_o}, 32'd0);
    arr_raddr_i = 12'd0; cyc();
    check("R1 array erased", {24'd0, arr_rdata_o}, 32'hFF);
    arr_raddr_i = 12'(DEPTH-1); cyc();
    check("R1 array last", {24'd0, arr_rdata_o}, 32'hFF);
    sp_roff_i = 5'd7; cyc();
    check("R1 scratch zero", {24'd0, sp_rdata_o}, 32'h00);

    // R9 out of range reads
    arr_raddr_i = 12'(DEPTH); cyc();
    check("R9 beyond end", {24'd0, arr_rdata_o}, 32'h00);
    arr_raddr_i = 12'hFFF; cyc();
    check("R9 top address", {24'd0, arr_rdata_o}, 32'h00);

    // R2 start and write together: write dropped
    sp_addr_i = {7'd4, 5'd9}; sp_start_i = 1; sp_wdata_i = 8'h5A; sp_we_i = 1;
    cyc(); sp_start_i = 0; sp_we_i = 0;
    m_tgt = {7'd4, 5'd9}; m_ptr = 5'd9; m_end = 5'd9; m_mask = 0;
    check("R2 end after start", {27'd0, end_off_o}, 32'd9);
    sp_roff_i = 5'd9; cyc();
    check("R2 write dropped", {24'd0, sp_rdata_o}, 32'h00);
    // R5 copy with nothing written is refused
    grp_mode_i = '0;
    do_copy({m_tgt, m_end}, 0);

    // R3 wrap within page
    sp_begin({7'd3, 5'd30});
    sp_put(8'h11); sp_put(8'h22); sp_put(8'h33); sp_put(8'h44);
    check("R3 end wraps", {27'd0, end_off_o}, 32'd1);
    check("R3 tgt kept", {20'd0, tgt_addr_o}, {20'd0, 7'd3, 5'd30});
    verify_sp("R4 readback");
    do_copy({m_tgt, m_end}, 1);
    verify_page(3, "R7 wrapped commit");

    // R6 overwrite then AND merge in group 0
    grp_mode_i = '0;
    sp_begin({7'd2, 5'd0}); sp_put(8'h3C); do_copy({m_tgt, m_end}, 0);
    grp_mode_i = 20'b10;
    sp_begin({7'd2, 5'd0}); sp_put(8'hF0); do_copy({m_tgt, m_end}, 0);
    arr_raddr_i = {7'd2, 5'd0}; cyc();
    check("R6 and merge", {24'd0, arr_rdata_o}, 32'h30);

    // R6 code 11 refuses
    grp_mode_i = 20'b11 << 2;
    sp_begin({7'd9, 5'd4}); sp_put(8'h00); do_copy({m_tgt, m_end}, 0);
    verify_page(9, "R6 locked page");

    // R5 page beyond 79
    sp_begin({7'd100, 5'd0}); sp_put(8'h00); do_copy({m_tgt, m_end}, 0);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int pg = ($urandom_range(0, 9) == 0) ? $urandom_range(NPAGE, 127) : $urandom_range(0, NPAGE-1);
      int n  = $urandom_range(0, 40);
      logic [16:0] auth;
      grp_mode_i = 20'($urandom);
      sp_begin({7'(pg), 5'($urandom_range(0, 31))});
      for (int k = 0; k < n; k++) sp_put(8'($urandom));
      check("R3 end offset", {27'd0, end_off_o}, {27'd0, m_end});
      if (it % 4 == 0) verify_sp("R4 random readback");
      auth = {m_tgt, m_end};
      if ($urandom_range(0, 4) == 0) auth = auth ^ (17'd1 << $urandom_range(0, 16));
      do_copy(auth, (it % 3) == 0);
      if (pg < NPAGE) verify_page(pg, "R6/R7 random page");
    end

    finish_run();
  end
endmodule